// File: doc/BRIEF.md
# Trace filter control register

This block holds a small control word that decides two things for an on-chip trace unit. The first is whether trace output is permitted at the privilege level the processor is running at now. The second is which timebase supplies the timestamps attached to trace records. Software writes and reads the word through a plain register port with a write strobe. The block combines the stored word with several live inputs: the current privilege level, a global self-hosted trace enable, a free-running 64-bit physical counter, and two offsets.

Two enable bits are kept, one for the user level and one for the kernel level. The global self-hosted enable overrides both bits, and any level above kernel is never traced. A two-bit select field chooses the timestamp. It can be the raw counter, the counter minus a virtual offset, or the counter minus a guest physical offset. The guest physical offset counts as zero when that feature is absent. Both the permission output and the timestamp are registered. Access permission checking and the trace data path are handled elsewhere.

Top module: `trc_filter_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, the read port shows 0 and trace_allowed is 0. The timestamp output is 0 while reset is held.
- R2: A write stores only bit 0 (user enable), bit 1 (kernel enable) and bits 6:5 (timestamp select). Every other bit reads back as 0, and the new value is visible on the read port the cycle after the write strobe.
- R3: With select 2'b01, tstamp equals the counter minus the virtual offset, modulo 2^64. It is registered, so it shows the inputs sampled at the previous clock edge.
- R4: With select 2'b10, tstamp equals the counter minus the guest physical offset when gphys_off_present is 1. When gphys_off_present is 0, tstamp equals the counter.
- R5: With select 2'b11, tstamp equals the raw counter.
- R6: With select 2'b00, tstamp equals the raw counter and reserved_ts is 1. For the other three select values reserved_ts is 0. This flag is registered alongside tstamp.
- R7: With the self-hosted enable high, trace_allowed at level 0 follows bit 0 and at level 1 follows bit 1. It is registered one cycle behind its inputs.
- R8: When the self-hosted enable is low, trace_allowed is 0 whatever the enable bits hold.
- R9: At privilege levels 2 and 3, trace_allowed is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Current control word, with unused bits reading 0 |
| priv_lvl | input | 2 | Current privilege level (0 user, 1 kernel, 2 and 3 higher) |
| sh_trace_en | input | 1 | Global self-hosted trace enable |
| phys_cnt | input | 64 | Free-running physical counter |
| virt_off | input | 64 | Virtual offset |
| gphys_off | input | 64 | Guest physical offset |
| gphys_off_present | input | 1 | The guest physical offset feature exists |
| trace_allowed | output | 1 | Trace permitted at the current level (registered) |
| tstamp | output | 64 | Selected timestamp (registered) |
| reserved_ts | output | 1 | The reserved select value is in use (registered) |

## Verification
The assertions assume that every input is stable across each clock edge. They also assume that reset is held for at least two edges, so the stored word and the output stages start from known values. The bench changes inputs only on the falling clock edge and holds reset for several cycles. It samples one full rising edge after each change, so every registered output has settled on a single set of inputs. Counter and offset values are chosen to include a wrap below zero, so the modulo subtraction is checked at its boundary.

// File: rtl/trc_filter_pkg.sv
package trc_filter_pkg;
  localparam int REG_W      = 32;
  localparam int CNT_W      = 64;
  localparam int LVL_W      = 2;
  localparam int NUM_EN_LVL = 2;
  localparam int TS_LSB     = 5;
  localparam int TS_W       = 2;

  typedef enum logic [TS_W-1:0] {
    TS_RSVD  = 2'b00,
    TS_VIRT  = 2'b01,
    TS_GPHYS = 2'b10,
    TS_PHYS  = 2'b11
  } ts_sel_e;

  function automatic logic [REG_W-1:0] wr_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_EN_LVL; i++) m[i] = 1'b1;
    for (int i = 0; i < TS_W; i++) m[TS_LSB+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/trc_cfg_reg.sv
module trc_cfg_reg #(
  parameter int REG_W = 32,
  parameter logic [REG_W-1:0] WMASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_data & WMASK;
  end

  // R2: stored value is the write data with unused bits cleared
  a_r2_masked_write: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) && !$past(rst) |-> q == ($past(wr_data) & WMASK));
  // R2: no write, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) && !$past(rst) |-> $stable(q));
endmodule

// File: rtl/trc_gate.sv
module trc_gate #(
  parameter int LVL_W  = 2,
  parameter int NUM_EN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sh_en,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [NUM_EN-1:0] en,
  output logic              allowed
);
  logic [NUM_EN-1:0] hit;

  for (genvar g = 0; g < NUM_EN; g++) begin : g_lvl
    assign hit[g] = en[g] && (lvl == LVL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) allowed <= 1'b0;
    else     allowed <= sh_en && (|hit);
  end

  // R8: global enable low forces no trace
  a_r8_sh_gate: assert property (@(posedge clk) disable iff (rst)
    !$past(sh_en) |-> !allowed);
  // R9: levels above the enable range never trace
  a_r9_high_lvl: assert property (@(posedge clk) disable iff (rst)
    ($past(lvl) >= LVL_W'(NUM_EN)) |-> !allowed);
  // R7: trace only when the matching bit was set
  a_r7_needs_bit: assert property (@(posedge clk) disable iff (rst)
    allowed |-> ($past(en) != '0));
endmodule

// File: rtl/trc_tstamp.sv
module trc_tstamp
  import trc_filter_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  ts_sel_e          sel,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] voff,
  input  logic [CNT_W-1:0] goff,
  input  logic             goff_vld,
  output logic [CNT_W-1:0] tstamp,
  output logic             rsvd
);
  logic [CNT_W-1:0] goff_eff;
  logic [CNT_W-1:0] ts_d;

  assign goff_eff = goff_vld ? goff : '0;

  always_comb begin
    unique case (sel)
      TS_VIRT:  ts_d = cnt - voff;
      TS_GPHYS: ts_d = cnt - goff_eff;
      default:  ts_d = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tstamp <= '0;
      rsvd   <= 1'b0;
    end else begin
      tstamp <= ts_d;
      rsvd   <= (sel == TS_RSVD);
    end
  end

  // R5: physical selection passes the counter
  a_r5_raw: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(sel) == TS_PHYS |-> tstamp == $past(cnt));
  // R3: virtual selection subtracts the virtual offset
  a_r3_virt: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(sel) == TS_VIRT |-> tstamp + $past(voff) == $past(cnt));
  // R4: absent offset feature means no subtraction
  a_r4_no_goff: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(sel) == TS_GPHYS && !$past(goff_vld) |-> tstamp == $past(cnt));
  // R6: reserved flag tracks the reserved select value
  a_r6_flag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rsvd == ($past(sel) == TS_RSVD));
endmodule

// File: rtl/trc_filter_ctl.sv
module trc_filter_ctl
  import trc_filter_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int CW = CNT_W,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_en,
  input  logic [RW-1:0] reg_wr_data,
  output logic [RW-1:0] reg_rd_data,
  input  logic [LW-1:0] priv_lvl,
  input  logic          sh_trace_en,
  input  logic [CW-1:0] phys_cnt,
  input  logic [CW-1:0] virt_off,
  input  logic [CW-1:0] gphys_off,
  input  logic          gphys_off_present,
  output logic          trace_allowed,
  output logic [CW-1:0] tstamp,
  output logic          reserved_ts
);
  localparam logic [RW-1:0] MASK = RW'(wr_mask());

  logic [RW-1:0] cfg;
  ts_sel_e       ts_sel;

  trc_cfg_reg #(.REG_W(RW), .WMASK(MASK)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_data(reg_wr_data), .q(cfg)
  );

  assign reg_rd_data = cfg;
  assign ts_sel      = ts_sel_e'(cfg[TS_LSB +: TS_W]);

  trc_gate #(.LVL_W(LW), .NUM_EN(NUM_EN_LVL)) u_gate (
    .clk(clk), .rst(rst), .sh_en(sh_trace_en), .lvl(priv_lvl),
    .en(cfg[NUM_EN_LVL-1:0]), .allowed(trace_allowed)
  );

  trc_tstamp #(.CNT_W(CW)) u_ts (
    .clk(clk), .rst(rst), .sel(ts_sel), .cnt(phys_cnt), .voff(virt_off),
    .goff(gphys_off), .goff_vld(gphys_off_present),
    .tstamp(tstamp), .rsvd(reserved_ts)
  );

  // R1: first cycle out of reset shows a cleared word and no trace
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> reg_rd_data == '0 && !trace_allowed);
endmodule

// File: tb/sim_trc_filter_ctl.sv
module sim_trc_filter_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic [1:0]  priv_lvl = 2'd0;
  logic        sh_trace_en = 1'b0;
  logic [63:0] phys_cnt = '0, virt_off = '0, gphys_off = '0;
  logic        gphys_off_present = 1'b0;
  logic        trace_allowed;
  logic [63:0] tstamp;
  logic        reserved_ts;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trc_filter_ctl u0 (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .priv_lvl(priv_lvl), .sh_trace_en(sh_trace_en),
    .phys_cnt(phys_cnt), .virt_off(virt_off), .gphys_off(gphys_off),
    .gphys_off_present(gphys_off_present), .trace_allowed(trace_allowed),
    .tstamp(tstamp), .reserved_ts(reserved_ts)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rd", {32'd0, reg_rd_data}, 64'd0);
    chk("R1 allowed", {63'd0, trace_allowed}, 64'd0);
    chk("R1 tstamp", tstamp, 64'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 rd after", {32'd0, reg_rd_data}, 64'd0);
    chk("R1 allowed after", {63'd0, trace_allowed}, 64'd0);
  endtask

  task automatic t_regrw();
    wr(32'hFFFF_FFFF);
    chk("R2 all ones", {32'd0, reg_rd_data}, 64'h63);
    wr(32'hA5A5_A59C);
    chk("R2 pattern", {32'd0, reg_rd_data}, 64'h0);
    wr(32'h0000_0041);
    chk("R2 mixed", {32'd0, reg_rd_data}, 64'h41);
  endtask

  task automatic t_virt();
    wr(32'h20);
    phys_cnt = 64'd1000; virt_off = 64'd300; settle();
    chk("R3 virt", tstamp, 64'd700);
    chk("R6 flag low virt", {63'd0, reserved_ts}, 64'd0);
    phys_cnt = 64'd5; virt_off = 64'd10; settle();
    chk("R3 wrap", tstamp, 64'hFFFF_FFFF_FFFF_FFFB);
  endtask

  task automatic t_gphys();
    wr(32'h40);
    phys_cnt = 64'h1_0000_0000; gphys_off = 64'h10; gphys_off_present = 1'b1; settle();
    chk("R4 present", tstamp, 64'h0_FFFF_FFF0);
    gphys_off_present = 1'b0; settle();
    chk("R4 absent", tstamp, 64'h1_0000_0000);
  endtask

  task automatic t_raw();
    wr(32'h60);
    phys_cnt = 64'hDEAD_BEEF_0123_4567; virt_off = 64'd9; gphys_off = 64'd9;
    gphys_off_present = 1'b1; settle();
    chk("R5 raw", tstamp, 64'hDEAD_BEEF_0123_4567);
    chk("R6 flag low raw", {63'd0, reserved_ts}, 64'd0);
  endtask

  task automatic t_rsvd();
    wr(32'h00);
    phys_cnt = 64'h55; virt_off = 64'h5; settle();
    chk("R6 rsvd ts", tstamp, 64'h55);
    chk("R6 rsvd flag", {63'd0, reserved_ts}, 64'd1);
  endtask

  task automatic t_enable();
    sh_trace_en = 1'b1;
    wr(32'h1);
    priv_lvl = 2'd0; settle();
    chk("R7 user on", {63'd0, trace_allowed}, 64'd1);
    priv_lvl = 2'd1; settle();
    chk("R7 kernel off", {63'd0, trace_allowed}, 64'd0);
    wr(32'h2);
    settle();
    chk("R7 kernel on", {63'd0, trace_allowed}, 64'd1);
    priv_lvl = 2'd0; settle();
    chk("R7 user off", {63'd0, trace_allowed}, 64'd0);
  endtask

  task automatic t_shgate();
    wr(32'h3);
    sh_trace_en = 1'b0;
    for (int l = 0; l < 2; l++) begin
      priv_lvl = 2'(l); settle();
      chk("R8 gated", {63'd0, trace_allowed}, 64'd0);
    end
    sh_trace_en = 1'b1; settle();
    chk("R8 ungated", {63'd0, trace_allowed}, 64'd1);
  endtask

  task automatic t_high();
    wr(32'h3);
    sh_trace_en = 1'b1;
    for (int l = 2; l < 4; l++) begin
      priv_lvl = 2'(l); settle();
      chk("R9 high level", {63'd0, trace_allowed}, 64'd0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_regrw();
    t_virt();
    t_gphys();
    t_raw();
    t_rsvd();
    t_enable();
    t_shgate();
    t_high();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule